// File: doc/BRIEF.md
# Iterative Unsigned Divider with Operand-Scaled Latency

This block divides one unsigned W-bit integer by another and returns the quotient and the remainder together. It works in two phases. First it scales the divisor up by doubling, keeping a one-hot weight alongside it, until the scaled divisor exceeds the dividend. Then it walks back down one bit per clock: wherever the scaled divisor still fits into the running dividend, it subtracts it and sets the matching quotient bit. Small quotients finish in a few cycles, and large ones take up to about twice W cycles.

A caller presents the operands with a one-cycle `start` while the block is idle. It then waits for the one-cycle `done` pulse and reads `quotient`, `remainder` and `div_by_zero`. These results stay steady until the next accepted start. A zero divisor bypasses both phases and completes at once with a flagged result.

Top module: `shiftsub_div`

## Requirements
- R1: When `done` is high and the divisor was non-zero, `quotient` equals floor(dividend / divisor) of the operands captured at the accepted start.
- R2: When `done` is high and the divisor was non-zero, `remainder` equals dividend mod divisor, and it never grows during the subtract phase.
- R3: Let k be the smallest count with divisor·2^k > dividend. Then `done` is high exactly 2k+2 rising edges after the edge that accepted `start`, and it is low in every cycle before that.
- R4: A zero divisor gives `done` on the first edge after acceptance, with `div_by_zero` = 1, `quotient` all ones and `remainder` equal to the dividend.
- R5: `done` lasts exactly one cycle, and the results hold their values in the cycle after it.
- R6: A `start` raised while a division is running is ignored. The running result still reflects the operands first accepted, even if the operand inputs have changed.
- R7: After reset, `done`, `quotient`, `remainder` and `div_by_zero` are all zero.
- R8: `div_by_zero` is 0 at `done` for every non-zero divisor.
- R9: The scaled divisor keeps one bit beyond W. A dividend of 2^W-1 divided by 1 therefore yields quotient 2^W-1 and remainder 0, with k = W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; honoured only while idle |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| done | output | 1 | One-cycle pulse marking valid results |
| quotient | output | W | Quotient |
| remainder | output | W | Remainder |
| div_by_zero | output | 1 | Set when the divisor was zero |

## Verification
The bench builds the block at W = 8. At that width the deepest normalisation (divisor 1 against dividend 255, nine weight positions) and the all-ones zero-divisor quotient can be hit directly. A grid over both operands and a few hundred random pairs cover every shift count from 0 to 8. The cycle-exact latency rule lets a reference model predict `done` on every clock. The model also predicts the final values, including runs where `start` and the operands are disturbed mid-operation.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_REST = 2'd2,
    ST_FIN  = 2'd3
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        div_zero,
  input  logic        dsr_gt,
  input  logic        pwr_last,
  output sdiv_state_e state,
  output logic        done
);
  sdiv_state_e state_q, state_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)    state_d = div_zero ? ST_FIN : ST_NORM;
      ST_NORM: if (dsr_gt)   state_d = ST_REST;
      ST_REST: if (pwr_last) state_d = ST_FIN;
      ST_FIN:                state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
  assign done  = (state_q == ST_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
endmodule

// File: rtl/sdiv_path.sv
module sdiv_path
  import sdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  sdiv_state_e    state,
  input  logic           start,
  input  logic [W-1:0]   dividend,
  input  logic [W-1:0]   divisor,
  output logic           div_zero,
  output logic           dsr_gt,
  output logic           pwr_last,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           div_by_zero
);
  localparam int WX = W + 1;
  localparam logic [WX-1:0] PWR_ONE = WX'(1);

  logic [W-1:0]  dvd_q, dvd_d;
  logic [WX-1:0] dsr_q, dsr_d;
  logic [WX-1:0] pwr_q, pwr_d;
  logic [W-1:0]  quo_q, quo_d;
  logic          dz_q, dz_d;
  logic          load_en, fits;

  assign div_zero = (divisor == '0);
  assign load_en  = (state == ST_IDLE) && start;
  assign dsr_gt   = dsr_q > {1'b0, dvd_q};
  assign fits     = !dsr_gt;
  assign pwr_last = (pwr_q == PWR_ONE);

  // Next-value logic for the datapath registers
  always_comb begin
    dvd_d = dvd_q;
    dsr_d = dsr_q;
    pwr_d = pwr_q;
    quo_d = quo_q;
    dz_d  = dz_q;
    if (load_en) begin
      dvd_d = dividend;
      dsr_d = {1'b0, divisor};
      pwr_d = PWR_ONE;
      quo_d = div_zero ? '1 : '0;
      dz_d  = div_zero;
    end else if (state == ST_NORM) begin
      if (!dsr_gt) begin
        dsr_d = dsr_q << 1;
        pwr_d = pwr_q << 1;
      end
    end else if (state == ST_REST) begin
      if (fits) begin
        dvd_d = dvd_q - dsr_q[W-1:0];
        quo_d = quo_q | pwr_q[W-1:0];
      end
      dsr_d = dsr_q >> 1;
      pwr_d = pwr_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q <= '0;
      dsr_q <= '0;
      pwr_q <= '0;
      quo_q <= '0;
      dz_q  <= 1'b0;
    end else begin
      dvd_q <= dvd_d;
      dsr_q <= dsr_d;
      pwr_q <= pwr_d;
      quo_q <= quo_d;
      dz_q  <= dz_d;
    end
  end

  assign quotient    = quo_q;
  assign remainder   = dvd_q;
  assign div_by_zero = dz_q;

  AST_REM_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REST) |=> (dvd_q <= $past(dvd_q))); // R2
  AST_PWR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORM || state == ST_REST) |-> ($countones(pwr_q) == 1)); // R3
  AST_NO_TOP_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REST && pwr_q[W]) |-> dsr_gt); // R9
endmodule

// File: rtl/shiftsub_div.sv
module shiftsub_div
  import sdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  sdiv_state_e state;
  logic div_zero, dsr_gt, pwr_last;

  sdiv_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .div_zero (div_zero),
    .dsr_gt   (dsr_gt),
    .pwr_last (pwr_last),
    .state    (state),
    .done     (done)
  );

  sdiv_path #(.W(W)) u_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .div_zero    (div_zero),
    .dsr_gt      (dsr_gt),
    .pwr_last    (pwr_last),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
  );

  AST_DZ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (&quotient)); // R4
endmodule

// File: tb/shiftsub_div_tb.sv
module shiftsub_div_tb_top;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         done;
  logic [W-1:0] quotient, remainder;
  logic         div_by_zero;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shiftsub_div #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .done(done), .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: behavioural latency and results; optional mid-run disturbance
  task automatic run_div(input int a, input int b, input bit disturb);
    int k, lat, d, eq, er, ez;
    k = 0;
    if (b != 0) begin
      d = b;
      while (d <= a) begin d = d << 1; k++; end
      lat = 2 * k + 2;
      eq = a / b; er = a % b; ez = 0;
    end else begin
      lat = 0; eq = MAXV; er = a; ez = 1;
    end
    @(negedge clk);
    dividend = W'(a); divisor = W'(b); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= lat + 1; n++) begin
      if (n > 0) @(negedge clk);
      if (disturb && lat >= 4 && n == 1) begin
        dividend = W'(a ^ 8'h5a); divisor = W'(b + 3); start = 1'b1;  // R6 stimulus
      end
      if (disturb && n == 2) start = 1'b0;
      if (n <= lat) chk(done == (n == lat), "R3 done timing", int'(done), int'(n == lat));
      else          chk(done == 1'b0, "R5 done single pulse", int'(done), 0);
      if (n == lat || n == lat + 1) begin
        chk(quotient == W'(eq), disturb ? "R6 quotient after ignored start" :
            (b == 0 ? "R4 zero-divisor quotient" : "R1 quotient"), int'(quotient), eq);
        chk(remainder == W'(er), disturb ? "R6 remainder after ignored start" :
            (b == 0 ? "R4 zero-divisor remainder" : "R2 remainder"), int'(remainder), er);
        chk(div_by_zero == ez[0], b == 0 ? "R4 flag" : "R8 flag clear",
            int'(div_by_zero), ez);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(done == 1'b0, "R7 done at reset", int'(done), 0);
    chk(quotient == '0, "R7 quotient at reset", int'(quotient), 0);
    chk(remainder == '0, "R7 remainder at reset", int'(remainder), 0);
    chk(div_by_zero == 1'b0, "R7 flag at reset", int'(div_by_zero), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_div(94, 7, 1'b0);          // R1 R2 R3: k=4, q=13 r=3
    run_div(MAXV, 1, 1'b0);        // R9 widest normalisation
    run_div(0, 5, 1'b0);
    run_div(3, 200, 1'b0);
    run_div(200, 200, 1'b0);
    run_div(MAXV, MAXV, 1'b0);
    run_div(128, 0, 1'b0);         // R4
    run_div(0, 0, 1'b0);           // R4
    run_div(250, 3, 1'b1);         // R6
    run_div(MAXV, 1, 1'b1);        // R6

    for (int a = 0; a <= MAXV; a += 17)
      for (int b = 0; b <= MAXV; b += 13)
        run_div(a, b, 1'b0);

    for (int i = 0; i < 400; i++)
      run_div(int'($urandom_range(MAXV, 0)), int'($urandom_range(MAXV, 0)), i[3]);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule